// File: doc/BRIEF.md
# Page Write Buffer with Commit Control

This block sits between a serial bus slave and slow non-volatile backing storage. During a write transaction it gathers data bytes into a four-byte page buffer. The page is aligned so that the two low address bits select a lane. The first byte sets the page and the starting lane. Each later byte goes to the next lane, and after lane 3 the lane returns to lane 0.

When the bus signals STOP, the buffered page goes out on a commit port as a single beat. The beat carries a mask of the lanes that were written. For a slow commit, a busy output then stays high for a fixed number of clocks, which stands in for the storage write cycle. An inhibit input allows fast commits. With inhibit set, a page whose registers all have volatile copies is committed with no busy period. If any byte in the page targets a register that exists only in backing storage, the full write cycle still applies. Strobes that arrive while busy are discarded, and a sticky flag records that this happened.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset, busy, dropped and cm_valid are 0.
- R2: The first byte written into an empty buffer lands in lane wr_addr[1:0], and its wr_addr[AW-1:2] becomes the page (cm_page). Each following byte lands in the next lane modulo 4, and its wr_addr is ignored. Lane i occupies cm_data[8i+7:8i], and cm_mask bit i marks lane i as written.
- R3: When more than four bytes are written, the lanes wrap, so each lane holds the last byte written to it and cm_mask is 4'b1111.
- R4: No commit beat appears while bytes are being written. cm_valid rises only in the cycle after a STOP is sampled.
- R5: A STOP sampled with at least one buffered byte gives a cm_valid pulse of exactly one cycle, in the next cycle. Unwritten lanes carry zero, and the buffer is empty afterwards.
- R6: When inhibit is 0, or any buffered byte was written with nv_only=1, the commit has cm_slow=1. Busy is then high for exactly CYCLES cycles, starting in the cycle of cm_valid.
- R7: When inhibit is 1 and no buffered byte had nv_only=1, the commit has cm_slow=0 and busy stays low.
- R8: A strobe while busy is high is discarded: it changes no buffered lane, and it sets dropped, which stays at 1 until reset.
- R9: A STOP sampled with an empty buffer produces no cm_valid and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Byte write strobe from the bus slave |
| wr_addr | input | AW | Register address (used on the first byte only) |
| wr_data | input | 8 | Byte data |
| nv_only | input | 1 | Target exists only in backing storage |
| stop | input | 1 | End of bus transaction |
| inhibit | input | 1 | Suppress slow commit for registers with volatile copies |
| busy | output | 1 | Slow write cycle in progress |
| dropped | output | 1 | Sticky: a strobe was discarded while busy |
| cm_valid | output | 1 | One-cycle commit beat |
| cm_page | output | AW-2 | Page number of the commit |
| cm_data | output | 32 | Four lanes of page data |
| cm_mask | output | 4 | Lanes written |
| cm_slow | output | 1 | Commit needs the full write cycle |

## Verification
A wrong lane pointer or page latch appears on the next commit beat as misplaced bytes or mask bits, one cycle after STOP. A miscounted write-cycle timer shows as a busy window that is too short or too long, which is visible at the busy pin. An error in how nv_only bits are accumulated shows as a wrong cm_slow value and a missing or extra busy window in the same commit. A buffer that is not cleared shows on the following transaction as stale lanes, or as a commit produced by an empty STOP.

// File: rtl/page_commit_buffer.sv
module page_commit_buffer #(
  parameter int AW     = 8,
  parameter int CYCLES = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          nv_only,
  input  logic          stop,
  input  logic          inhibit,
  output logic          busy,
  output logic          dropped,
  output logic          cm_valid,
  output logic [AW-3:0] cm_page,
  output logic [31:0]   cm_data,
  output logic [3:0]    cm_mask,
  output logic          cm_slow
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [31:0]   data_q;
  logic [3:0]    mask_q;
  logic [1:0]    ptr_q;
  logic [AW-3:0] page_q;
  logic          nv_q;
  logic [CW-1:0] cnt_q;

  wire       first  = (mask_q == 4'b0);
  wire [1:0] lane   = first ? wr_addr[1:0] : ptr_q;
  wire       accept = wr_stb && !busy && !stop;
  wire       launch = stop && !busy && !first;
  wire       slow   = !inhibit || nv_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      mask_q   <= '0;
      ptr_q    <= '0;
      page_q   <= '0;
      nv_q     <= 1'b0;
      cnt_q    <= '0;
      dropped  <= 1'b0;
      cm_valid <= 1'b0;
      cm_page  <= '0;
      cm_data  <= '0;
      cm_mask  <= '0;
      cm_slow  <= 1'b0;
    end else begin
      cm_valid <= 1'b0;
      if (busy) cnt_q <= cnt_q - CW'(1);
      if (wr_stb && busy) dropped <= 1'b1;
      if (launch) begin
        cm_valid <= 1'b1;
        cm_page  <= page_q;
        cm_data  <= data_q;
        cm_mask  <= mask_q;
        cm_slow  <= slow;
        if (slow) cnt_q <= CW'(CYCLES);
        data_q   <= '0;
        mask_q   <= '0;
        nv_q     <= 1'b0;
      end else if (accept) begin
        data_q[lane*8 +: 8] <= wr_data;
        mask_q[lane]        <= 1'b1;
        ptr_q               <= lane + 2'd1;
        nv_q                <= nv_q | nv_only;
        if (first) page_q <= wr_addr[AW-1:2];
      end
    end
  end
endmodule

// File: rtl/page_commit_buffer_chk.sv
module page_commit_buffer_chk #(
  parameter int CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic wr_stb,
  input logic stop,
  input logic busy,
  input logic dropped,
  input logic cm_valid,
  input logic cm_slow
);
  logic [31:0] run_q;
  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 32'd1;
    else run_q <= '0;
  end

  // R5
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> !cm_valid);
  // R4
  beat_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cm_valid) |-> $past(stop));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cm_valid && cm_slow);
  // R7
  fast_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid && !cm_slow) |-> !busy);
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_q < 32'(CYCLES));
  // R8
  dropped_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> dropped);
  // R8
  dropped_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dropped) |-> $past(wr_stb && busy));
endmodule

bind page_commit_buffer page_commit_buffer_chk #(.CYCLES(CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .stop(stop), .busy(busy),
  .dropped(dropped), .cm_valid(cm_valid), .cm_slow(cm_slow)
);

// File: tb/page_commit_buffer_tb.sv
module page_commit_buffer_tb;
  localparam int AW = 8;
  localparam int CYC = 7;

  logic clk = 0, rst_n = 0, wr_stb = 0, nv_only = 0, stop = 0, inhibit = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic busy, dropped, cm_valid, cm_slow;
  logic [AW-3:0] cm_page;
  logic [31:0] cm_data;
  logic [3:0] cm_mask;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  page_commit_buffer #(.AW(AW), .CYCLES(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .nv_only(nv_only), .stop(stop), .inhibit(inhibit), .busy(busy), .dropped(dropped),
    .cm_valid(cm_valid), .cm_page(cm_page), .cm_data(cm_data), .cm_mask(cm_mask),
    .cm_slow(cm_slow));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d, input logic nv);
    @(negedge clk);
    wr_stb = 1; wr_addr = a; wr_data = d; nv_only = nv;
    @(negedge clk);
    wr_stb = 0; nv_only = 0;
  endtask

  // drives STOP; returns at the negedge where the commit beat should be visible
  task automatic do_stop();
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int nb;
    int t;
    logic [31:0] edata;
    logic [3:0] emask;
    logic eslow;
    repeat (3) @(negedge clk);
    // R1
    check(busy === 0 && dropped === 0 && cm_valid === 0, "R1", {busy, dropped, cm_valid}, 0);
    rst_n = 1;

    t = 0;
    for (int off = 0; off < 4; off++)
      for (int n = 1; n <= 6; n++)
        for (int mode = 0; mode < 4; mode++) begin
          logic [AW-3:0] pg;
          logic seen;
          pg = (AW-2)'(t * 5 + 3);
          inhibit = mode[0];
          edata = '0; emask = '0; seen = 0;
          for (int j = 0; j < n; j++) begin
            logic [7:0] d;
            logic [1:0] ln;
            d = 8'(t * 7 + j * 29 + 3);
            ln = 2'((off + j) % 4);
            edata[ln*8 +: 8] = d;
            emask[ln] = 1'b1;
            // later addresses are garbage: must be ignored (R2)
            wr(j == 0 ? {pg, 2'(off)} : AW'(t * 13 + j), d, (mode[1] && j == n - 1));
            if (!seen) begin
              // R4
              check(cm_valid === 0, "R4", cm_valid, 0);
              seen = 1;
            end
          end
          eslow = !mode[0] || mode[1];
          do_stop();
          // R5
          check(cm_valid === 1, "R5", cm_valid, 1);
          // R2 / R3
          check(cm_data === edata, n > 4 ? "R3" : "R2", cm_data, edata);
          check(cm_mask === emask, n > 4 ? "R3" : "R2", cm_mask, emask);
          check(cm_page === pg, "R2", cm_page, pg);
          check(cm_slow === eslow, eslow ? "R6" : "R7", cm_slow, eslow);
          count_busy(nb);
          check(nb == (eslow ? CYC : 0), eslow ? "R6" : "R7", nb, eslow ? CYC : 0);
          if (!eslow) @(negedge clk);
          check(cm_valid === 0, "R5", cm_valid, 0);
          t++;
        end

    // R9: STOP with empty buffer
    inhibit = 0;
    do_stop();
    check(cm_valid === 0 && busy === 0, "R9", {cm_valid, busy}, 0);

    // R8: strobe while busy
    wr(8'h40, 8'hA5, 0);
    do_stop();
    check(busy === 1, "R6", busy, 1);
    wr(8'h41, 8'h5A, 0);
    check(dropped === 1, "R8", dropped, 1);
    count_busy(nb);
    do_stop();
    check(cm_valid === 0, "R8", cm_valid, 0);
    wr(8'h22, 8'h33, 0);
    do_stop();
    check(cm_data === 32'h0033_0000 && cm_mask === 4'b0100, "R8",
          {cm_data, cm_mask}, {32'h0033_0000, 4'b0100});
    check(dropped === 1, "R8", dropped, 1);
    count_busy(nb);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule